// File: doc/BRIEF.md
# Sub-DAC Control Encoder with Background Calibration Dither

This block sits in one stage of a pipelined converter. Each clock it takes the 13 comparator outputs of the stage's flash quantizer and produces the ternary control word for the stage's capacitor sub-DAC. The quantizer output is resolved into a signed decision from -6 to +6. There are two zero codes, a negative zero and a positive zero, so the polarity of a near-zero input is not lost. In normal operation the six sub-DAC controls form a thermometer code of that decision.

When a nonzero calibration selector names one of the six controls, that control is taken out of the thermometer mapping. The decision is spread over the other five controls in ascending order. The named control is then driven from a pseudo-random dither. In the positive region the dither toggles between common mode and the negative reference. In the negative region it toggles between common mode and the positive reference. This keeps the residue inside its range. Each region has its own free-running maximal-length LFSR, so neither dither source is correlated with the signal. Side-band tags give the dither state and the generator in use, so a downstream correlator can sort the back-end samples. All outputs are registered, so the tags stay aligned with the control word.

Top module: `subdac_cal_enc`

## Requirements
- R1: The decision is the count k of ones on `cmp_i`, with no position weighting, so bubbles are tolerated. For k of 0 to 6 the decision is negative with magnitude 6-k (k=6 is the negative zero). For k of 7 to 13 it is positive with magnitude k-7 (k=7 is the positive zero).
- R2: Each control field j (1 to 6) occupies `ctl_o[2j-1:2j-2]` and is coded 2'b00 for common mode, 2'b01 for the positive reference and 2'b10 for the negative reference. No field ever carries 2'b11.
- R3: With the selector at 0, field j takes the decision's reference level when j is at most the magnitude, and common mode otherwise.
- R4: With the selector s in 1..6 and magnitude at most 5, the other fields are ranked 1..5 in ascending field order. A field whose rank is at most the magnitude takes the decision's reference level, and every other field is at common mode. Field s carries the dither.
- R5: At magnitude 6 every field is at full scale (all 2'b01 for +6, all 2'b10 for -6), whatever the selector, and `dith_vld_o` is low.
- R6: In the positive region the dither comes from generator A, and a dither bit of 1 drives field s to 2'b10. In the negative region it comes from generator B, and a dither bit of 1 drives field s to 2'b01. A dither bit of 0 gives 2'b00.
- R7: Each generator is a 7-bit Fibonacci LFSR that shifts left. Its new LSB is bit6 XOR bit5, and its dither bit is the current bit6. The seeds are 7'h01 for A and 7'h55 for B. Both generators advance on every clock while out of reset, and reset reloads the seeds.
- R8: `dith_vld_o` is high exactly when a dither field is present (R4). `dith_gen_o` is 0 for A and 1 for B, and `dith_bit_o` is the dither bit. Both are 0 while `dith_vld_o` is low.
- R9: A selector value of 7 behaves exactly as 0.
- R10: All outputs are registered with one clock of latency and are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 13 | Comparator outputs of the stage quantizer |
| cal_sel_i | input | 3 | Calibration selector, 0 = normal mode |
| ctl_o | output | 12 | Six ternary sub-DAC control fields |
| dith_vld_o | output | 1 | A dithered field is present |
| dith_gen_o | output | 1 | Generator in use, 0 = A, 1 = B |
| dith_bit_o | output | 1 | Current dither bit |

## Verification
A wrong rank offset or an off-by-one in the zero split corrupts one control field within a single clock, and only for particular selector and decision pairs. For that reason every selector is swept against every comparator count. A generator with a wrong tap or seed only shows as a mismatched dither bit. The bench tracks both sequences for more than a full period, and across a reset in the middle of the run, and compares them every clock. A tag that drifts a cycle away from its control word is visible at once, because the expected model compares the whole registered output set on the same edge.

// File: rtl/subdac_pkg.sv
package subdac_pkg;
  typedef enum logic [1:0] {
    LV_CM  = 2'b00,
    LV_POS = 2'b01,
    LV_NEG = 2'b10
  } lvl_e;
endpackage

// File: rtl/subdac_dec_count.sv
module subdac_dec_count #(
  parameter int NCTL = 6,
  localparam int NCMP = 2*NCTL+1,
  localparam int CNTW = $clog2(NCMP+1),
  localparam int MAGW = $clog2(NCTL+1)
) (
  input  logic [NCMP-1:0] cmp_i,
  output logic            neg_o,
  output logic [MAGW-1:0] mag_o
);
  logic [CNTW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NCMP; i++) cnt = cnt + CNTW'(cmp_i[i]);
  end

  always_comb begin
    neg_o = (cnt <= CNTW'(NCTL));
    if (neg_o) mag_o = MAGW'(CNTW'(NCTL) - cnt);
    else       mag_o = MAGW'(cnt - CNTW'(NCTL+1));
  end
endmodule

// File: rtl/subdac_lfsr.sv
module subdac_lfsr #(
  parameter int W = 7,
  parameter logic [W-1:0] TAPS = 7'b1100000,
  parameter logic [W-1:0] SEED = 7'h01
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_o
);
  logic [W-1:0] st_q, st_d;

  always_comb st_d = {st_q[W-2:0], ^(st_q & TAPS)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign bit_o = st_q[W-1];
endmodule

// File: rtl/subdac_ctl_map.sv
module subdac_ctl_map
  import subdac_pkg::*;
#(
  parameter int NCTL = 6,
  localparam int MAGW = $clog2(NCTL+1)
) (
  input  logic              neg_i,
  input  logic [MAGW-1:0]   mag_i,
  input  logic [MAGW-1:0]   sel_i,
  input  logic              dith_a_i,
  input  logic              dith_b_i,
  output logic [2*NCTL-1:0] ctl_o,
  output logic              vld_o,
  output logic              gen_o,
  output logic              bit_o
);
  logic cal_on, full;
  lvl_e lvl, dlvl;
  logic dbit;

  always_comb begin
    cal_on = (sel_i != '0) && (sel_i <= MAGW'(NCTL));
    full   = (mag_i == MAGW'(NCTL));
    lvl    = neg_i ? LV_NEG : LV_POS;
    dlvl   = neg_i ? LV_POS : LV_NEG;
    dbit   = neg_i ? dith_b_i : dith_a_i;
    vld_o  = cal_on && !full;
    gen_o  = vld_o && neg_i;
    bit_o  = vld_o && dbit;
  end

  for (genvar j = 0; j < NCTL; j++) begin : g_fld
    localparam logic [MAGW-1:0] JV = MAGW'(j+1);
    logic [MAGW-1:0] rank;
    lvl_e f;
    always_comb begin
      rank = (JV < sel_i) ? JV : JV - MAGW'(1);
      if (full)                        f = lvl;
      else if (!cal_on)                f = (JV <= mag_i) ? lvl : LV_CM;
      else if (JV == sel_i)            f = dbit ? dlvl : LV_CM;
      else                             f = (rank <= mag_i) ? lvl : LV_CM;
    end
    assign ctl_o[2*j+1:2*j] = f;
  end
endmodule

// File: rtl/subdac_cal_enc.sv
module subdac_cal_enc #(
  parameter int NCTL = 6,
  parameter int LFSR_W = 7,
  parameter logic [LFSR_W-1:0] TAPS   = 7'b1100000,
  parameter logic [LFSR_W-1:0] SEED_A = 7'h01,
  parameter logic [LFSR_W-1:0] SEED_B = 7'h55,
  localparam int NCMP = 2*NCTL+1,
  localparam int MAGW = $clog2(NCTL+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCMP-1:0]   cmp_i,
  input  logic [MAGW-1:0]   cal_sel_i,
  output logic [2*NCTL-1:0] ctl_o,
  output logic              dith_vld_o,
  output logic              dith_gen_o,
  output logic              dith_bit_o
);
  logic            neg;
  logic [MAGW-1:0] mag;
  logic            da, db;
  logic [2*NCTL-1:0] ctl_d;
  logic            vld_d, gen_d, bit_d;

  subdac_dec_count #(.NCTL(NCTL)) u_dec (.cmp_i(cmp_i), .neg_o(neg), .mag_o(mag));

  subdac_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED_A)) u_gen_a (.clk(clk), .rst_n(rst_n), .bit_o(da));
  subdac_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED_B)) u_gen_b (.clk(clk), .rst_n(rst_n), .bit_o(db));

  subdac_ctl_map #(.NCTL(NCTL)) u_map (
    .neg_i(neg), .mag_i(mag), .sel_i(cal_sel_i),
    .dith_a_i(da), .dith_b_i(db),
    .ctl_o(ctl_d), .vld_o(vld_d), .gen_o(gen_d), .bit_o(bit_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_o      <= '0;
      dith_vld_o <= 1'b0;
      dith_gen_o <= 1'b0;
      dith_bit_o <= 1'b0;
    end else begin
      ctl_o      <= ctl_d;
      dith_vld_o <= vld_d;
      dith_gen_o <= gen_d;
      dith_bit_o <= bit_d;
    end
  end
endmodule

// File: rtl/subdac_cal_enc_chk.sv
module subdac_cal_enc_chk #(
  parameter int NCTL = 6,
  localparam int NCMP = 2*NCTL+1,
  localparam int MAGW = $clog2(NCTL+1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCMP-1:0]   cmp_i,
  input logic [MAGW-1:0]   cal_sel_i,
  input logic [2*NCTL-1:0] ctl_o,
  input logic              dith_vld_o,
  input logic              dith_gen_o,
  input logic              dith_bit_o
);
  logic sel_ok;
  assign sel_ok = (cal_sel_i != '0) && (cal_sel_i <= MAGW'(NCTL));

  for (genvar j = 0; j < NCTL; j++) begin : g_code
    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[2*j+1:2*j] != 2'b11);
  end

  // R5
  top_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cmp_i) == NCMP) |=> (ctl_o == {NCTL{2'b01}}) && !dith_vld_o);

  // R5
  bottom_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cmp_i) == 0) |=> (ctl_o == {NCTL{2'b10}}) && !dith_vld_o);

  // R9
  no_dither_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> !dith_vld_o);

  // R8
  tag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dith_vld_o |-> !dith_gen_o && !dith_bit_o);

  // R6
  gen_a_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && $countones(cmp_i) > NCTL && $countones(cmp_i) < NCMP)
      |=> dith_vld_o && !dith_gen_o);

  // R6
  gen_b_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && $countones(cmp_i) <= NCTL && $countones(cmp_i) > 0)
      |=> dith_vld_o && dith_gen_o);
endmodule

bind subdac_cal_enc subdac_cal_enc_chk #(.NCTL(NCTL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .cal_sel_i(cal_sel_i),
  .ctl_o(ctl_o), .dith_vld_o(dith_vld_o), .dith_gen_o(dith_gen_o),
  .dith_bit_o(dith_bit_o)
);

// File: tb/tb_subdac_cal_enc.sv
`timescale 1ns/1ps
module tb_subdac_cal_enc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] cmp_i;
  logic [2:0]  cal_sel_i;
  logic [11:0] ctl_o;
  logic        dith_vld_o, dith_gen_o, dith_bit_o;

  int checks = 0, fails = 0;
  int ma, mb;
  bit have_exp = 0;
  logic [11:0] e_ctl;
  logic e_vld, e_gen, e_bit;
  string e_tag;

  always #2.5 clk = ~clk;

  subdac_cal_enc dut (.clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .cal_sel_i(cal_sel_i),
    .ctl_o(ctl_o), .dith_vld_o(dith_vld_o), .dith_gen_o(dith_gen_o), .dith_bit_o(dith_bit_o));

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [12:0] therm(int k);
    return 13'((32'd1 << k) - 1);
  endfunction

  task automatic compare(string tag);
    checks++;
    if (ctl_o !== e_ctl || dith_vld_o !== e_vld || dith_gen_o !== e_gen || dith_bit_o !== e_bit) begin
      fails++;
      $display("FAIL %s: got ctl=%h vld=%b gen=%b bit=%b, expected ctl=%h vld=%b gen=%b bit=%b",
               tag, ctl_o, dith_vld_o, dith_gen_o, dith_bit_o, e_ctl, e_vld, e_gen, e_bit);
    end
  endtask

  // Behavioural reference: integer decision, ranks and LFSR model.
  task automatic apply(logic [12:0] c, logic [2:0] s, string tag);
    int k, d, mag, lvl, dl, rank, sel, bitv;
    bit neg, cal, full;
    cmp_i = c; cal_sel_i = s;
    k = $countones(c);                       // R1
    neg = (k <= 6);
    d = neg ? k - 6 : k - 7;
    mag = (d < 0) ? -d : d;
    sel = (s == 3'd7) ? 0 : int'(s);         // R9
    cal = (sel != 0);
    full = (mag == 6);
    lvl = neg ? 2 : 1;
    dl  = neg ? 1 : 2;
    bitv = neg ? ((mb >> 6) & 1) : ((ma >> 6) & 1);
    e_ctl = '0;
    for (int j = 1; j <= 6; j++) begin
      int f;
      if (full) f = lvl;                                  // R5
      else if (!cal) f = (j <= mag) ? lvl : 0;            // R3
      else if (j == sel) f = bitv ? dl : 0;               // R6
      else begin
        rank = (j < sel) ? j : j - 1;                     // R4
        f = (rank <= mag) ? lvl : 0;
      end
      e_ctl[2*j-1 -: 2] = 2'(f);
    end
    e_vld = cal && !full;                                 // R8
    e_gen = e_vld && neg;
    e_bit = e_vld && (bitv != 0);
    // R7: advance both generators
    ma = ((ma << 1) | (((ma >> 6) ^ (ma >> 5)) & 1)) & 127;
    mb = ((mb << 1) | (((mb >> 6) ^ (mb >> 5)) & 1)) & 127;
    e_tag = tag;
    have_exp = 1;
  endtask

  task automatic step(logic [12:0] c, logic [2:0] s, string tag);
    @(negedge clk);
    if (have_exp) compare(e_tag);
    apply(c, s, tag);
  endtask

  task automatic check_reset_zero();
    checks++;
    if (ctl_o !== '0 || dith_vld_o !== 1'b0 || dith_gen_o !== 1'b0 || dith_bit_o !== 1'b0) begin
      fails++;
      $display("FAIL R10: reset outputs ctl=%h vld=%b gen=%b bit=%b, expected all 0",
               ctl_o, dith_vld_o, dith_gen_o, dith_bit_o);
    end
  endtask

  task automatic release_reset(logic [12:0] c, logic [2:0] s, string tag);
    @(negedge clk);
    rst_n = 1'b1;
    ma = 32'h01; mb = 32'h55;
    apply(c, s, tag);
  endtask

  initial begin
    rst_n = 1'b0; cmp_i = '0; cal_sel_i = '0;
    repeat (3) @(negedge clk);
    check_reset_zero();                                   // R10
    release_reset(therm(13), 3'd0, "R5");
    // R3 normal mode across all counts
    for (int k = 0; k <= 13; k++) step(therm(k), 3'd0, "R3");
    // R4 every selector against every count
    for (int s = 1; s <= 6; s++)
      for (int k = 0; k <= 13; k++) step(therm(k), 3'(s), "R4");
    // R9 selector 7
    for (int k = 0; k <= 13; k++) step(therm(k), 3'd7, "R9");
    // R1 bubbles: counts 6 and 7 with scattered ones
    step(13'b0000001011111, 3'd2, "R1");
    step(13'b0000010111111, 3'd2, "R1");
    step(13'b1000000111111, 3'd0, "R1");
    step(13'b0101010101010, 3'd5, "R1");
    // R6/R7 long dither runs in both regions
    for (int n = 0; n < 140; n++) step(therm(9), 3'd3, "R6");
    for (int n = 0; n < 140; n++) step(therm(4), 3'd1, "R7");
    // mixed traffic
    for (int n = 0; n < 400; n++) step(therm($urandom_range(13)), 3'($urandom_range(7)), "R4");
    // R7 reseed by a mid-run reset
    @(negedge clk);
    compare(e_tag);
    have_exp = 0;
    rst_n = 1'b0;
    #1 check_reset_zero();                                // R10
    release_reset(therm(10), 3'd6, "R7");
    for (int n = 0; n < 60; n++) step(therm(10 - (n % 8)), 3'd6, "R7");
    @(negedge clk);
    compare(e_tag);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule